// File: doc/BRIEF.md
# Permuting Inbound Buffer for a Time-Multiplexed Mesh Model

This block sits on the receive side of a port in a network simulator where one physical router model is time-multiplexed over many logical nodes. In each model cycle the router model visits instances 0 to N-1 in order, where N is the product of a runtime width W and a runtime height H. The sending side pushes one slot per instance in that order, and the receiving side pops one slot per instance in the same order. Between the two sides, the buffer reorders the slots so that each instance receives the message its mesh neighbour sent instead of its own.

Storage is split into two banks. The sender fills one bank while the receiver drains the other in permuted order. Once both sides have finished N transfers, the banks swap on the following clock edge, which gives the port a latency of one model cycle. Each slot carries a present flag, so an instance that sent nothing reads back as empty. Four reorder modes cover the horizontal pair of directions (a rotation within each row of W) and the vertical pair (a shift of W slots across the whole sequence). A ring of N nodes is the special case H = 1.

Top module: `mux_port_reorder`

## Requirements
- R1: After reset, `in_ready` is 1, `out_avail` is 1, and all N slots of the read bank are empty (`out_present` = 0), so the first model cycle reads N empty messages.
- R2: `in_ready` stays 1 until N pushes have been accepted in the current model cycle and is 0 after that. A push while `in_ready` is 0 is ignored.
- R3: `out_avail` falls after N pops. It returns only after the bank swap, which happens on the clock edge following the cycle in which both sides have completed N transfers. After the swap, `in_ready` is 1 again.
- R4: A message pushed in model cycle t is popped in model cycle t+1. The two banks alternate, so data from cycle t is never seen in cycle t+2.
- R5: `cfg_mode` = 0 (row, last to front): the r-th pop with column p = r mod W returns slot r+W-1 when p = 0, and slot r-1 otherwise.
- R6: `cfg_mode` = 1 (row, first to back): the r-th pop returns slot r-W+1 when p = W-1, and slot r+1 otherwise.
- R7: `cfg_mode` = 2 (first W to end): the r-th pop returns slot (r+W) mod N.
- R8: `cfg_mode` = 3 (last W to front): the r-th pop returns slot (r+N-W) mod N.
- R9: The present flag pushed with a slot is returned on `out_present` when that slot is popped. An absent sender yields `out_present` = 0 at its receiver.
- R10: Only slots with index below N = W*H are ever read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | DIM_W | Mesh width W, at least 1 |
| cfg_height | input | DIM_W | Mesh height H, at least 1, with W*H no larger than MAX_NODES |
| cfg_mode | input | 2 | Reorder mode 0..3 |
| in_push | input | 1 | Push the slot of the next sending instance |
| in_present | input | 1 | The sending instance has a message |
| in_data | input | DATA_W | Message payload |
| in_ready | output | 1 | The write bank can accept another slot |
| out_pop | input | 1 | Pop the slot for the next receiving instance |
| out_avail | output | 1 | The read bank has a slot left for this model cycle |
| out_present | output | 1 | The popped slot holds a message |
| out_data | output | DATA_W | Payload of the popped slot |

## Verification
The bench builds the block with MAX_NODES = 16 and DATA_W = 8. With these values, every one of the four modes can be swept across square, wide, tall, single-row, single-column and single-node meshes, including the full 16-slot case. Each run covers three model cycles, so the bench sees the initial empty cycle, the alternation of the two banks, a rejected push on a full bank, and an absent sender that moves with each round.

// File: rtl/mux_port_reorder.sv
module mux_port_reorder #(
  parameter int MAX_NODES = 16,
  parameter int DATA_W    = 8,
  localparam int DIM_W    = $clog2(MAX_NODES + 1),
  localparam int SLOT_W   = $clog2(MAX_NODES),
  localparam int CW       = 2 * DIM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIM_W-1:0]  cfg_width,
  input  logic [DIM_W-1:0]  cfg_height,
  input  logic [1:0]        cfg_mode,
  input  logic              in_push,
  input  logic              in_present,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              out_pop,
  output logic              out_avail,
  output logic              out_present,
  output logic [DATA_W-1:0] out_data
);

  logic [DATA_W-1:0]    dat [2][MAX_NODES];
  logic [MAX_NODES-1:0] vld [2];
  logic                 wbank;
  logic [CW-1:0]        wr_cnt, rd_cnt, rd_col, rd_base, src;

  wire [CW-1:0] w     = CW'(cfg_width);
  wire [CW-1:0] n_act = CW'(cfg_width) * CW'(cfg_height);
  wire          rbank = ~wbank;
  wire          swap  = (wr_cnt == n_act) && (rd_cnt == n_act);
  wire          wr_go = in_push && in_ready;
  wire          rd_go = out_pop && out_avail;
  wire [SLOT_W-1:0] wr_slot = wr_cnt[SLOT_W-1:0];
  wire [SLOT_W-1:0] rd_slot = src[SLOT_W-1:0];

  assign in_ready    = wr_cnt < n_act;
  assign out_avail   = rd_cnt < n_act;
  assign out_data    = dat[rbank][rd_slot];
  assign out_present = out_avail && vld[rbank][rd_slot];

  always_comb begin
    case (cfg_mode)
      2'd0:    src = (rd_col == '0) ? rd_base + w - CW'(1) : rd_cnt - CW'(1);
      2'd1:    src = (rd_col == w - CW'(1)) ? rd_base : rd_cnt + CW'(1);
      2'd2:    src = (rd_cnt + w < n_act) ? rd_cnt + w : rd_cnt + w - n_act;
      default: src = (rd_cnt < w) ? rd_cnt + n_act - w : rd_cnt - w;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbank   <= 1'b0;
      wr_cnt  <= '0;
      rd_cnt  <= '0;
      rd_col  <= '0;
      rd_base <= '0;
      vld[0]  <= '0;
      vld[1]  <= '0;
    end else if (swap) begin
      wbank   <= ~wbank;
      wr_cnt  <= '0;
      rd_cnt  <= '0;
      rd_col  <= '0;
      rd_base <= '0;
    end else begin
      if (wr_go) begin
        vld[wbank][wr_slot] <= in_present;
        wr_cnt <= wr_cnt + CW'(1);
      end
      if (rd_go) begin
        rd_cnt <= rd_cnt + CW'(1);
        if (rd_col == w - CW'(1)) begin
          rd_col  <= '0;
          rd_base <= rd_base + w;
        end else begin
          rd_col <= rd_col + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go && !swap) dat[wbank][wr_slot] <= in_data;
  end

  a_r2_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (in_push && !in_ready && !swap) |=> $stable(wr_cnt));

  a_r3_drain_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && rd_cnt == n_act - CW'(1)) |=> !out_avail);

  a_r3_swap_reopens: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> (out_avail && in_ready && rd_cnt == '0));

  a_r4_bank_flip: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> (wbank != $past(wbank)));

  a_r10_src_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_avail |-> (src < n_act));

endmodule

// File: tb/mux_port_reorder_tb.sv
module mux_port_reorder_tb;
  localparam int MAXN = 16;
  localparam int DW   = 8;
  localparam int DIMW = $clog2(MAXN + 1);

  logic clk = 0, rst_n = 0;
  logic [DIMW-1:0] cfg_width = 1, cfg_height = 1;
  logic [1:0] cfg_mode = 0;
  logic in_push = 0, in_present = 0, out_pop = 0;
  logic [DW-1:0] in_data = 0;
  logic in_ready, out_avail, out_present;
  logic [DW-1:0] out_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mux_port_reorder #(.MAX_NODES(MAXN), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_mode(cfg_mode), .in_push(in_push), .in_present(in_present),
    .in_data(in_data), .in_ready(in_ready), .out_pop(out_pop),
    .out_avail(out_avail), .out_present(out_present), .out_data(out_data));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (W=%0d H=%0d mode=%0d)",
               req, act, exp, cfg_width, cfg_height, cfg_mode);
    end
  endtask

  function automatic int exp_src(int r, int w, int n, int m);
    int p = r % w;
    case (m)
      0: return (p == 0) ? r + w - 1 : r - 1;
      1: return (p == w - 1) ? r - w + 1 : r + 1;
      2: return (r + w) % n;
      default: return (r + n - w) % n;
    endcase
  endfunction

  function automatic string mode_req(int m);
    case (m)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic idle();
    @(negedge clk);
    in_push = 0; out_pop = 0;
  endtask

  task automatic push(input bit pres, input int data, input bit expect_ready);
    @(negedge clk);
    out_pop = 0; in_push = 1; in_present = pres; in_data = DW'(data);
    #1;
    check(in_ready == expect_ready, "R2 in_ready", in_ready, expect_ready);
  endtask

  // rnd 0 is the initial empty cycle; otherwise slots carry (rnd<<5)|sender
  task automatic pop_round(input int rnd, input int w, input int n, input int m, input int skip);
    for (int r = 0; r < n; r++) begin
      int s;
      @(negedge clk);
      in_push = 0; out_pop = 1;
      #1;
      s = exp_src(r, w, n, m);
      check(out_avail == 1, "R3 avail", out_avail, 1);
      if (rnd == 0) begin
        check(out_present == 0, "R1 empty", out_present, 0);
      end else if (s == skip) begin
        check(out_present == 0, "R9 absent", out_present, 0);
      end else begin
        check(out_present == 1, "R9 present", out_present, 1);
        check(int'(out_data) == ((rnd << 5) | s), {mode_req(m), " R4 data"},
              int'(out_data), (rnd << 5) | s);
      end
    end
    @(negedge clk);
    in_push = 0; out_pop = 1;
    #1;
    check(out_avail == 0, "R3 drained", out_avail, 0);
  endtask

  task automatic push_round(input int rnd, input int n, input int skip);
    for (int i = 0; i < n; i++) push(i != skip, (rnd << 5) | i, 1'b1);
    push(1'b1, 8'hFF, 1'b0);
  endtask

  task automatic run(input int w, input int h, input int m);
    int n = w * h;
    int sk1 = (1 + m) % n;
    int sk2 = (2 + m) % n;
    @(negedge clk);
    rst_n = 0; in_push = 0; out_pop = 0;
    cfg_width = DIMW'(w); cfg_height = DIMW'(h); cfg_mode = 2'(m);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    check(in_ready == 1, "R1 ready", in_ready, 1);
    check(out_avail == 1, "R1 avail", out_avail, 1);
    check(out_present == 0, "R1 present", out_present, 0);
    pop_round(0, w, n, m, -1);
    push_round(1, n, sk1);
    pop_round(1, w, n, m, sk1);
    push_round(2, n, sk2);
    pop_round(2, w, n, m, sk2);
    idle();
  endtask

  initial begin
    int ws[7] = '{4, 2, 3, 1, 5, 1, 8};
    int hs[7] = '{4, 3, 2, 5, 1, 1, 2};
    for (int c = 0; c < 7; c++)
      for (int m = 0; m < 4; m++)
        run(ws[c], hs[c], m);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule